// File: doc/BRIEF.md
# Result Latency Scoreboard with Pair-Dependent Bypass

This block sits beside the issue logic of an in-order core. It keeps one entry for each architectural register in two register files: 32 integer and 32 floating-point. When an instruction issues with a register result, the entry for its destination records the kind of operation that produced it, and a counter restarts to measure the cycles since issue. A later instruction asks whether its source operands may be read. It gives its source register numbers, its own operation class, and one flag per source that marks the operand as the data value of a store. The block answers ready or not-ready for each source.

The answer is not a single latency per producer. The required distance in cycles depends on the pairing of producer class and consumer class. Some integer pairs forward after one cycle. Store data can take an integer ALU result in the very cycle it issues. Multiplies give store data one cycle early. Floating-point ops chained to other floating-point ops see a shortened distance. Operations that produce no register result leave the scoreboard untouched. The last register in each file reads as zero and is never pending.

Top module: `sb_scoreboard`

## Requirements
- R1: After reset every register of both files reports ready to every consumer class.
- R2: Register numbers are 6 bits: bit 5 selects the file (0 integer, 1 floating) and bits 4:0 the index. Index 31 of either file always reports ready, and an issue to it changes nothing.
- R3: Class codes are 0 none, 1 integer add/logic, 2 shift/conditional move, 3 integer compare, 4 32-bit multiply, 5 64-bit multiply, 6 floating add/multiply/copy/conditional move, 7 single divide, 8 double divide, 9 load, 10 branch, 11 trap, 12 store, and 13 to 15 unused. A source written by an issue in cycle t is ready in cycle t+N exactly when N is at least the pair latency; a source whose last writer reached its latency stays ready until it is rewritten.
- R4: Classes 1, 2 and 3 have latency 2 by default. Class 1 reaches consumers of class 10, 1, 2, 3, 4 or 5 after 1 cycle. Class 3 reaches class 10 after 1 cycle.
- R5: Results of classes 1, 2 and 3 reach a class-12 consumer whose operand is flagged as store data with latency 0: ready in the very cycle the producer issues. An unflagged store operand (the address) gets the default latency.
- R6: Class 4 has latency 21, or 20 into flagged store data. Class 5 has latency 23, or 22 into flagged store data.
- R7: Class 6 has latency 6, or 4 when the consumer is also class 6.
- R8: Class 7 has latency 34 and class 8 has latency 63, for every consumer.
- R9: Class 9 has latency 3.
- R10: An issue of class 0, 10, 11, 12 or 13 to 15 leaves the destination's entry unchanged.
- R11: A new issue with a result to a pending register replaces its class and restarts its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst | input | 6 | Destination register of the issuing instruction |
| iss_cls | input | 4 | Operation class of the issuing instruction |
| qry_src | input | 12 | Source registers of the querying instruction, source k in bits 6k+5:6k |
| qry_cls | input | 4 | Operation class of the querying instruction |
| qry_store_data | input | 2 | Per source: operand is the data value of a store |
| qry_ready | output | 2 | Per source: operand may be read this cycle |

## Verification
A corrupted class tag would show at once as a wrong answer for the consumer classes whose pairing differs. An example is a multiply that forwards like an ALU op. A stuck or mis-stepped counter shows only at the latency boundary of its producer, up to 63 cycles after the issue. The bench therefore checks every cycle around each boundary, from one cycle before it to one cycle after. A broken write decode shows in the cycle after the issue, either as a pending entry left ready or as a no-result issue that disturbs an entry.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int LAT_W = 6;

    typedef enum logic [3:0] {
        CLS_NONE   = 4'd0,
        CLS_IALU   = 4'd1,
        CLS_ISHF   = 4'd2,
        CLS_ICMP   = 4'd3,
        CLS_MUL32  = 4'd4,
        CLS_MUL64  = 4'd5,
        CLS_FPOP   = 4'd6,
        CLS_FDIVS  = 4'd7,
        CLS_FDIVD  = 4'd8,
        CLS_LOAD   = 4'd9,
        CLS_BRANCH = 4'd10,
        CLS_TRAP   = 4'd11,
        CLS_STORE  = 4'd12
    } op_cls_e;

    typedef struct packed {
        logic [3:0]       cls;
        logic [LAT_W-1:0] cnt;
    } sb_ent_t;

    // True for classes that write a register result.
    function automatic logic has_result(logic [3:0] c);
        return (c >= CLS_IALU) && (c <= CLS_LOAD);
    endfunction

    // Cycles between producer issue and the first cycle the consumer may read.
    function automatic logic [LAT_W-1:0] pair_latency(logic [3:0] p, logic [3:0] c, logic sd);
        logic fast_int;
        logic st_data;
        logic [LAT_W-1:0] lat;
        fast_int = (c == CLS_BRANCH) || (c == CLS_IALU) || (c == CLS_ISHF) ||
                   (c == CLS_ICMP) || (c == CLS_MUL32) || (c == CLS_MUL64);
        st_data  = (c == CLS_STORE) && sd;
        case (p)
            CLS_IALU:  lat = fast_int ? 6'd1 : (st_data ? 6'd0 : 6'd2);
            CLS_ISHF:  lat = st_data ? 6'd0 : 6'd2;
            CLS_ICMP:  lat = (c == CLS_BRANCH) ? 6'd1 : (st_data ? 6'd0 : 6'd2);
            CLS_MUL32: lat = st_data ? 6'd20 : 6'd21;
            CLS_MUL64: lat = st_data ? 6'd22 : 6'd23;
            CLS_FPOP:  lat = (c == CLS_FPOP) ? 6'd4 : 6'd6;
            CLS_FDIVS: lat = 6'd34;
            CLS_FDIVD: lat = 6'd63;
            CLS_LOAD:  lat = 6'd3;
            default:   lat = 6'd0;
        endcase
        return lat;
    endfunction

endpackage

// File: rtl/sb_entry.sv
module sb_entry
    import sb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_cls,
    output sb_ent_t    ent_o
);

    sb_ent_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (wr_en) begin
            ent_d.cls = wr_cls;
            ent_d.cnt = LAT_W'(1);
        end else if (ent_q.cnt != {LAT_W{1'b1}}) begin
            ent_d.cnt = ent_q.cnt + LAT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q.cls <= CLS_NONE;
            ent_q.cnt <= {LAT_W{1'b1}};
        end else begin
            ent_q <= ent_d;
        end
    end

    assign ent_o = ent_q;

endmodule

// File: rtl/sb_port.sv
module sb_port
    import sb_pkg::*;
#(
    parameter int NREG_FILE = 32,
    parameter int IDX_W     = 5,
    parameter int REG_W     = 6,
    parameter int NREG      = 64
) (
    input  logic [REG_W-1:0] src,
    input  logic [3:0]       cons_cls,
    input  logic             store_data,
    input  logic             iss_valid,
    input  logic [REG_W-1:0] iss_dst,
    input  logic [3:0]       iss_cls,
    input  sb_ent_t          ent [NREG],
    output logic             ready
);

    logic             is_zero;
    logic             fwd_hit;
    logic [LAT_W-1:0] lat_old;
    logic [LAT_W-1:0] lat_new;
    sb_ent_t          sel;

    always_comb begin
        sel     = ent[src];
        is_zero = (src[IDX_W-1:0] == IDX_W'(NREG_FILE - 1));
        fwd_hit = iss_valid && has_result(iss_cls) && (iss_dst == src);
        lat_old = pair_latency(sel.cls, cons_cls, store_data);
        lat_new = pair_latency(iss_cls, cons_cls, store_data);
        if (is_zero) begin
            ready = 1'b1;
        end else if (fwd_hit) begin
            ready = (lat_new == '0);
        end else begin
            ready = (sel.cnt >= lat_old);
        end
    end

endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
    import sb_pkg::*;
#(
    parameter  int NSRC      = 2,
    parameter  int NREG_FILE = 32,
    localparam int IDX_W     = $clog2(NREG_FILE),
    localparam int REG_W     = IDX_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  iss_valid,
    input  logic [REG_W-1:0]      iss_dst,
    input  logic [3:0]            iss_cls,
    input  logic [NSRC*REG_W-1:0] qry_src,
    input  logic [3:0]            qry_cls,
    input  logic [NSRC-1:0]       qry_store_data,
    output logic [NSRC-1:0]       qry_ready
);

    localparam int NREG = 2 * NREG_FILE;

    sb_ent_t ent [NREG];
    logic    iss_writes;

    assign iss_writes = iss_valid && has_result(iss_cls);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        if ((r % NREG_FILE) == NREG_FILE - 1) begin : g_zero
            assign ent[r] = '{cls: CLS_NONE, cnt: {LAT_W{1'b1}}};
        end else begin : g_live
            sb_entry u_ent (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (iss_writes && (iss_dst == REG_W'(r))),
                .wr_cls (iss_cls),
                .ent_o  (ent[r])
            );
        end
    end

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        sb_port #(
            .NREG_FILE (NREG_FILE),
            .IDX_W     (IDX_W),
            .REG_W     (REG_W),
            .NREG      (NREG)
        ) u_port (
            .src        (qry_src[k*REG_W +: REG_W]),
            .cons_cls   (qry_cls),
            .store_data (qry_store_data[k]),
            .iss_valid  (iss_valid),
            .iss_dst    (iss_dst),
            .iss_cls    (iss_cls),
            .ent        (ent),
            .ready      (qry_ready[k])
        );
    end

endmodule

// File: rtl/sb_chk.sv
module sb_chk #(
    parameter int NSRC  = 2,
    parameter int IDX_W = 5,
    parameter int REG_W = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  iss_valid,
    input logic [REG_W-1:0]      iss_dst,
    input logic [3:0]            iss_cls,
    input logic [NSRC*REG_W-1:0] qry_src,
    input logic [3:0]            qry_cls,
    input logic [NSRC-1:0]       qry_store_data,
    input logic [NSRC-1:0]       qry_ready
);

    for (genvar k = 0; k < NSRC; k++) begin : g_chk
        logic [REG_W-1:0] s;
        logic             zero_reg;
        assign s        = qry_src[k*REG_W +: REG_W];
        assign zero_reg = (s[IDX_W-1:0] == {IDX_W{1'b1}});

        a_r2_zero_ready: assert property (@(posedge clk) disable iff (!rst_n)
            zero_reg |-> qry_ready[k]);

        a_r5_store_fwd: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && iss_cls == 4'd1 && iss_dst == s && !zero_reg &&
             qry_cls == 4'd12 && qry_store_data[k]) |-> qry_ready[k]);

        a_r8_fdiv_pending: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(iss_valid && iss_cls == 4'd8) && s == $past(iss_dst) && !zero_reg &&
             !(iss_valid && iss_dst == s)) |-> !qry_ready[k]);

        a_r9_load_pending: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(iss_valid && iss_cls == 4'd9) && s == $past(iss_dst) && !zero_reg &&
             !(iss_valid && iss_dst == s)) |-> !qry_ready[k]);

        a_r3_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(qry_ready[k]) && $stable(s) && $stable(qry_cls) &&
             $stable(qry_store_data[k]) && !$past(iss_valid) && !iss_valid) |-> qry_ready[k]);
    end

endmodule

bind sb_scoreboard sb_chk #(
    .NSRC  (NSRC),
    .IDX_W (IDX_W),
    .REG_W (REG_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .iss_valid      (iss_valid),
    .iss_dst        (iss_dst),
    .iss_cls        (iss_cls),
    .qry_src        (qry_src),
    .qry_cls        (qry_cls),
    .qry_store_data (qry_store_data),
    .qry_ready      (qry_ready)
);

// File: tb/sim_sb_scoreboard.sv
`timescale 1ns/1ps
module sim_sb_scoreboard;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        iss_valid;
    logic [5:0]  iss_dst;
    logic [3:0]  iss_cls;
    logic [11:0] qry_src;
    logic [3:0]  qry_cls;
    logic [1:0]  qry_sd;
    logic [1:0]  rdy;

    int mcls [64];
    int mt   [64];
    int cyc;
    int n_chk;
    int n_bad;
    bit done;

    always #2.5 clk = ~clk;

    sb_scoreboard u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .iss_valid      (iss_valid),
        .iss_dst        (iss_dst),
        .iss_cls        (iss_cls),
        .qry_src        (qry_src),
        .qry_cls        (qry_cls),
        .qry_store_data (qry_sd),
        .qry_ready      (rdy)
    );

    function automatic int blat(int p, int c, bit sd);
        bit st = (c == 12) && sd;
        case (p)
            1: begin
                if (c == 10 || (c >= 1 && c <= 5)) return 1;
                return st ? 0 : 2;
            end
            2: return st ? 0 : 2;
            3: begin
                if (c == 10) return 1;
                return st ? 0 : 2;
            end
            4: return st ? 20 : 21;
            5: return st ? 22 : 23;
            6: return (c == 6) ? 4 : 6;
            7: return 34;
            8: return 63;
            9: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic bit bwrites(int c);
        return (c >= 1) && (c <= 9);
    endfunction

    function automatic bit bexp(int src, int c, bit sd, bit v, int dst, int cls);
        if ((src % 32) == 31) return 1'b1;
        if (v && bwrites(cls) && dst == src) return blat(cls, c, sd) == 0;
        if (mcls[src] == 0) return 1'b1;
        return (cyc - mt[src]) >= blat(mcls[src], c, sd);
    endfunction

    task automatic chk(bit act, bit exp, string tag, int src);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d reg %0d: ready=%0b expected %0b", tag, cyc, src, act, exp);
        end
    endtask

    task automatic step(bit v, int dst, int cls, int sa, int sb, int qc, bit sda, bit sdb, string tag);
        bit ea, eb;
        iss_valid = v;
        iss_dst   = 6'(dst);
        iss_cls   = 4'(cls);
        qry_src   = {6'(sb), 6'(sa)};
        qry_cls   = 4'(qc);
        qry_sd    = {sdb, sda};
        #1;
        ea = bexp(sa, qc, sda, v, dst, cls);
        eb = bexp(sb, qc, sdb, v, dst, cls);
        chk(rdy[0], ea, tag, sa);
        chk(rdy[1], eb, tag, sb);
        @(posedge clk);
        if (v && bwrites(cls) && (dst % 32) != 31) begin
            mcls[dst] = cls;
            mt[dst]   = cyc;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle(int n, int sa, int sb, int qc, bit sda, bit sdb, string tag);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, sa, sb, qc, sda, sdb, tag);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin
            mcls[i] = 0;
            mt[i]   = 0;
        end
        cyc = 0; n_chk = 0; n_bad = 0;
        rst_n = 1'b0; iss_valid = 1'b0; iss_dst = '0; iss_cls = '0;
        qry_src = '0; qry_cls = '0; qry_sd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every register ready after reset
        for (int i = 0; i < 32; i++) step(1'b0, 0, 0, i, i + 32, 8, 1'b0, 1'b0, "R1");

        // R2: zero registers ignore writes
        step(1'b1, 31, 8, 31, 63, 6, 1'b0, 1'b0, "R2");
        step(1'b1, 63, 8, 31, 63, 6, 1'b0, 1'b0, "R2");
        idle(2, 31, 63, 6, 1'b0, 1'b0, "R2");

        // R4: add/logic fast to branch, default 2 to store address
        step(1'b1, 1, 1, 0, 0, 0, 1'b0, 1'b0, "R4");
        idle(3, 1, 1, 10, 1'b0, 1'b0, "R4");
        step(1'b1, 1, 1, 0, 0, 0, 1'b0, 1'b0, "R4");
        idle(3, 1, 1, 12, 1'b0, 1'b0, "R4");
        step(1'b1, 2, 3, 0, 0, 0, 1'b0, 1'b0, "R4");
        idle(3, 2, 2, 10, 1'b0, 1'b0, "R4");
        step(1'b1, 2, 3, 0, 0, 0, 1'b0, 1'b0, "R4");
        idle(3, 2, 2, 1, 1'b0, 1'b0, "R4");

        // R5: same-cycle store data forwarding, address not forwarded
        step(1'b1, 4, 2, 4, 4, 12, 1'b1, 1'b0, "R5");
        idle(3, 4, 4, 12, 1'b1, 1'b0, "R5");
        step(1'b1, 36, 1, 36, 36, 12, 1'b1, 1'b0, "R5");

        // R6: multiply latencies, store data one cycle early
        step(1'b1, 5, 4, 0, 0, 0, 1'b0, 1'b0, "R6");
        idle(23, 5, 5, 12, 1'b1, 1'b0, "R6");
        step(1'b1, 5, 5, 0, 0, 0, 1'b0, 1'b0, "R6");
        idle(25, 5, 5, 12, 1'b1, 1'b0, "R6");

        // R7: floating op chained and unchained
        step(1'b1, 35, 6, 0, 0, 0, 1'b0, 1'b0, "R7");
        idle(6, 35, 35, 6, 1'b0, 1'b0, "R7");
        step(1'b1, 35, 6, 0, 0, 0, 1'b0, 1'b0, "R7");
        idle(8, 35, 35, 12, 1'b1, 1'b0, "R7");

        // R8: divides
        step(1'b1, 36, 7, 0, 0, 0, 1'b0, 1'b0, "R8");
        idle(36, 36, 36, 6, 1'b0, 1'b0, "R8");
        step(1'b1, 37, 8, 0, 0, 0, 1'b0, 1'b0, "R8");
        idle(66, 37, 37, 12, 1'b1, 1'b0, "R8");

        // R9: load
        step(1'b1, 6, 9, 0, 0, 0, 1'b0, 1'b0, "R9");
        idle(5, 6, 6, 12, 1'b1, 1'b0, "R9");

        // R10: no-result issues leave a pending multiply untouched
        step(1'b1, 7, 5, 0, 0, 0, 1'b0, 1'b0, "R10");
        step(1'b1, 7, 10, 7, 7, 1, 1'b0, 1'b0, "R10");
        step(1'b1, 7, 11, 7, 7, 1, 1'b0, 1'b0, "R10");
        step(1'b1, 7, 12, 7, 7, 1, 1'b0, 1'b0, "R10");
        step(1'b1, 7, 14, 7, 7, 1, 1'b0, 1'b0, "R10");
        idle(22, 7, 7, 1, 1'b0, 1'b0, "R10");

        // R11: overwrite of a pending divide by a short op
        step(1'b1, 8, 8, 0, 0, 0, 1'b0, 1'b0, "R11");
        idle(2, 8, 8, 1, 1'b0, 1'b0, "R11");
        step(1'b1, 8, 1, 8, 8, 1, 1'b0, 1'b0, "R11");
        idle(3, 8, 8, 6, 1'b0, 1'b0, "R11");

        // R3: constrained random traffic on a small register window
        for (int i = 0; i < 4000; i++) begin
            int sel_a, sel_b, d;
            sel_a = $urandom % 9;
            sel_b = $urandom % 9;
            d     = $urandom % 9;
            step(1'($urandom % 2),
                 int'($urandom % 2) * 32 + ((d == 8) ? 31 : d),
                 int'($urandom % 16),
                 int'($urandom % 2) * 32 + ((sel_a == 8) ? 31 : sel_a),
                 int'($urandom % 2) * 32 + ((sel_b == 8) ? 31 : sel_b),
                 int'($urandom % 16),
                 1'($urandom % 2), 1'($urandom % 2), "R3");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule